// File: doc/BRIEF.md
# Rotating Spare Bank Refresh Controller

This block keeps data alive in a ring of storage banks that lose their contents unless they are rewritten now and then. There are `NUM_BANKS` banks that hold live data plus one extra physical bank that holds nothing useful. That extra bank is the spare. A refresh step copies the bank just behind the spare in the ring into the spare, one word per cycle. When the copy is complete, the bank that was copied from becomes the new spare. Repeated steps walk the spare backwards around the ring, and each logical bank's data creeps forward one physical position per lap.

The host never sees this movement. It addresses a logical bank and a word. A small map register file translates each logical bank to its current physical bank, and the map changes in a single cycle at the end of each copy. While a copy is running, host reads of the bank being copied are served from the source. Host writes to that bank land in both the source and the spare, so no update is lost. Host access to the source has priority over the copy. The copy stalls for those cycles, and if the copy was about to write a word, it rewinds and reads that word again.

Decay is modelled only as a deadline. A step starts on request, or by itself once the ring has sat idle for `REFRESH_INTERVAL` cycles.

Top module: `rsb_refresh_ctrl`

## Requirements
- R1: During and right after synchronous reset, `spare_bank` equals `NUM_BANKS`, `refresh_busy` and `refresh_done` are 0, and `host_rvalid` is 0. Logical bank l starts in physical bank l.
- R2: A host read presented in cycle c (`host_en`=1, `host_we`=0) returns data with `host_rvalid`=1 in cycle c+2.
- R3: A read of logical bank l, word w returns the last value written there, no matter how many refresh steps or full laps of the ring have happened in between.
- R4: Each step copies from physical bank (spare+NUM_BANKS) mod (NUM_BANKS+1). When the step completes, that index becomes `spare_bank`. From reset, `spare_bank` therefore runs NUM_BANKS, NUM_BANKS-1, …, 0, NUM_BANKS, and it never changes at any other time.
- R5: `refresh_done` is a single-cycle pulse. It is raised in the first cycle with `refresh_busy`=0 after a step, and `spare_bank` already shows the new spare in that cycle.
- R6: A step with no host access to the source bank keeps `refresh_busy` high for exactly `BANK_WORDS`+2 cycles.
- R7: `refresh_req` sampled high while idle makes `refresh_busy` high in the next cycle. A request made while a step is running is dropped and does not queue another step.
- R8: With `refresh_req` low, a step starts by itself after exactly `REFRESH_INTERVAL` idle cycles.
- R9: A host write to the bank being copied, at any word and at any point in the copy, survives the step and later steps.
- R10: A host read of the bank being copied, made while the copy runs, returns that bank's current data.
- R11: Host accesses to the source bank stall the copy, so the step lasts longer than `BANK_WORDS`+2 cycles, but the step still completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_lbank | input | LB_W | Logical bank number |
| host_word | input | WA_W | Word address within the bank |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Registered read data |
| host_rvalid | output | 1 | Read data valid, two cycles after the request |
| refresh_req | input | 1 | Request one refresh step |
| refresh_busy | output | 1 | A copy step is in progress |
| refresh_done | output | 1 | One-cycle pulse when a step has committed |
| spare_bank | output | PB_W | Physical index of the current spare bank |

## Verification
The hardest situation to reach is a host write to the source bank that lands between the copy's read of a word and its write of that word into the spare. Only there does the rewind path decide whether the update survives. The bench reaches it by starting a step and, in the same cycles, sending back-to-back writes and reads to the logical bank it predicts is the source. Its own model of the map supplies that prediction. The bench then confirms that the step took longer than an undisturbed one and that every word of that bank reads back the newest value. Back-to-back steps with writes spread over all banks, run over two full laps, then confirm that the map still resolves every logical word correctly.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  typedef enum logic {
    RSB_IDLE = 1'b0,
    RSB_COPY = 1'b1
  } rsb_state_e;

  // Physical bank just behind idx on a ring of n+1 physical banks.
  function automatic int ring_pred(input int idx, input int n);
    return (idx == 0) ? n : idx - 1;
  endfunction

endpackage

// File: rtl/rsb_bank_ram.sv
module rsb_bank_ram #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 32,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];

  // Simple dual port, registered read: maps to block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rsb_bank_map.sv
module rsb_bank_map #(
  parameter int NUM_BANKS = 4,
  localparam int LB_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int PB_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LB_W-1:0] host_lbank,
  input  logic            commit,
  output logic [PB_W-1:0] host_phys,
  output logic [PB_W-1:0] src_phys,
  output logic [PB_W-1:0] spare_phys
);

  logic [PB_W-1:0] map_q [NUM_BANKS];
  logic [PB_W-1:0] spare_q;
  logic [LB_W-1:0] owner;

  always_comb begin
    src_phys = PB_W'(rsb_pkg::ring_pred(int'(spare_q), NUM_BANKS));
  end

  // Logical bank currently living in the source physical bank.
  always_comb begin
    owner = '0;
    for (int l = 0; l < NUM_BANKS; l++) begin
      if (map_q[l] == src_phys) owner = LB_W'(l);
    end
  end

  always_comb begin
    if (int'(host_lbank) < NUM_BANKS) host_phys = map_q[host_lbank];
    else                              host_phys = '0;
  end

  assign spare_phys = spare_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NUM_BANKS; l++) map_q[l] <= PB_W'(l);
      spare_q <= PB_W'(NUM_BANKS);
    end else if (commit) begin
      map_q[owner] <= spare_q;
      spare_q      <= src_phys;
    end
  end

endmodule

// File: rtl/rsb_copy_engine.sv
module rsb_copy_engine #(
  parameter int BANK_WORDS       = 32,
  parameter int REFRESH_INTERVAL = 256,
  localparam int WA_W            = $clog2(BANK_WORDS),
  localparam int AGE_W           = $clog2(REFRESH_INTERVAL + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            refresh_req,
  input  logic            src_rd,
  input  logic            src_wr,
  output logic            busy,
  output logic            done,
  output logic            commit,
  output logic            rd_issue,
  output logic [WA_W-1:0] rd_addr,
  output logic            wr_en,
  output logic [WA_W-1:0] wr_addr
);

  import rsb_pkg::*;

  rsb_state_e       state_q;
  logic [WA_W:0]    ptr_q;
  logic             s1_valid_q;
  logic [WA_W-1:0]  s1_addr_q;
  logic [AGE_W-1:0] age_q;
  logic             done_q;
  logic             start;
  logic             all_issued;

  assign busy       = (state_q == RSB_COPY);
  assign all_issued = (ptr_q >= (WA_W+1)'(BANK_WORDS));
  assign start      = !busy && (refresh_req || (age_q == AGE_W'(REFRESH_INTERVAL - 1)));
  assign rd_issue   = busy && !all_issued && !src_rd && !src_wr;
  assign rd_addr    = ptr_q[WA_W-1:0];
  assign wr_en      = s1_valid_q && !src_wr;
  assign wr_addr    = s1_addr_q;
  assign commit     = busy && all_issued && !s1_valid_q;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= RSB_IDLE;
      ptr_q      <= '0;
      s1_valid_q <= 1'b0;
      s1_addr_q  <= '0;
      age_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q     <= commit;
      s1_valid_q <= rd_issue;
      if (rd_issue) s1_addr_q <= rd_addr;
      if (start) begin
        state_q <= RSB_COPY;
        ptr_q   <= '0;
        age_q   <= '0;
      end else if (commit) begin
        state_q <= RSB_IDLE;
        age_q   <= '0;
      end else if (busy) begin
        if (s1_valid_q && src_wr) ptr_q <= {1'b0, s1_addr_q};   // rewind blocked word
        else if (rd_issue)        ptr_q <= ptr_q + (WA_W+1)'(1);
      end else begin
        age_q <= age_q + AGE_W'(1);
      end
    end
  end

endmodule

// File: rtl/rsb_refresh_ctrl.sv
module rsb_refresh_ctrl #(
  parameter int NUM_BANKS        = 4,
  parameter int BANK_WORDS       = 32,
  parameter int DATA_W           = 16,
  parameter int REFRESH_INTERVAL = 256,
  localparam int LB_W            = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int PB_W            = $clog2(NUM_BANKS + 1),
  localparam int WA_W            = $clog2(BANK_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [LB_W-1:0]   host_lbank,
  input  logic [WA_W-1:0]   host_word,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic              refresh_req,
  output logic              refresh_busy,
  output logic              refresh_done,
  output logic [PB_W-1:0]   spare_bank
);

  localparam int NUM_PHYS = NUM_BANKS + 1;

  logic [PB_W-1:0]   host_phys, src_phys, spare_phys;
  logic              host_valid, host_src, src_rd, src_wr;
  logic              cp_busy, cp_done, cp_commit, cp_issue, cp_wr_en;
  logic [WA_W-1:0]   cp_rd_addr, cp_wr_addr;
  logic [DATA_W-1:0] cp_wdata;
  logic [DATA_W-1:0] bank_rdata [NUM_PHYS];
  logic              rd_pend_q;
  logic [PB_W-1:0]   rd_phys_q;

  assign host_valid = host_en && (int'(host_lbank) < NUM_BANKS);
  assign host_src   = host_valid && cp_busy && (host_phys == src_phys);
  assign src_rd     = host_src && !host_we;
  assign src_wr     = host_src && host_we;
  assign cp_wdata   = bank_rdata[src_phys];

  rsb_bank_map #(.NUM_BANKS(NUM_BANKS)) map_i (
    .clk        (clk),
    .rst        (rst),
    .host_lbank (host_lbank),
    .commit     (cp_commit),
    .host_phys  (host_phys),
    .src_phys   (src_phys),
    .spare_phys (spare_phys)
  );

  rsb_copy_engine #(
    .BANK_WORDS       (BANK_WORDS),
    .REFRESH_INTERVAL (REFRESH_INTERVAL)
  ) copy_i (
    .clk         (clk),
    .rst         (rst),
    .refresh_req (refresh_req),
    .src_rd      (src_rd),
    .src_wr      (src_wr),
    .busy        (cp_busy),
    .done        (cp_done),
    .commit      (cp_commit),
    .rd_issue    (cp_issue),
    .rd_addr     (cp_rd_addr),
    .wr_en       (cp_wr_en),
    .wr_addr     (cp_wr_addr)
  );

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_bank
    logic              hit, is_spare, is_src, mirror;
    logic              we, re;
    logic [WA_W-1:0]   waddr, raddr;
    logic [DATA_W-1:0] wdata;

    assign hit      = host_valid && (host_phys == PB_W'(p));
    assign is_spare = (spare_phys == PB_W'(p));
    assign is_src   = (src_phys == PB_W'(p));
    assign mirror   = src_wr && is_spare;
    assign we       = (hit && host_we) || mirror || (cp_wr_en && is_spare);
    assign waddr    = (hit || mirror) ? host_word : cp_wr_addr;
    assign wdata    = (hit || mirror) ? host_wdata : cp_wdata;
    assign re       = (hit && !host_we) || (cp_issue && is_src);
    assign raddr    = hit ? host_word : cp_rd_addr;

    rsb_bank_ram #(.DATA_W(DATA_W), .WORDS(BANK_WORDS)) ram_i (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .re    (re),
      .raddr (raddr),
      .rdata (bank_rdata[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q   <= 1'b0;
      rd_phys_q   <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      rd_pend_q   <= host_valid && !host_we;
      rd_phys_q   <= host_phys;
      host_rvalid <= rd_pend_q;
      if (rd_pend_q) host_rdata <= bank_rdata[rd_phys_q];
    end
  end

  assign refresh_busy = cp_busy;
  assign refresh_done = cp_done;
  assign spare_bank   = spare_phys;

endmodule

// File: rtl/rsb_checker.sv
module rsb_checker #(
  parameter int NUM_BANKS        = 4,
  parameter int REFRESH_INTERVAL = 256,
  localparam int LB_W            = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int PB_W            = $clog2(NUM_BANKS + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            host_en,
  input logic            host_we,
  input logic [LB_W-1:0] host_lbank,
  input logic            host_rvalid,
  input logic            refresh_req,
  input logic            refresh_busy,
  input logic            refresh_done,
  input logic [PB_W-1:0] spare_bank
);

  int idle_cnt_q;

  always_ff @(posedge clk) begin
    if (rst || refresh_busy)                 idle_cnt_q <= 0;
    else if (idle_cnt_q <= REFRESH_INTERVAL) idle_cnt_q <= idle_cnt_q + 1;
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (host_en && !host_we && (int'(host_lbank) < NUM_BANKS)) |=> ##1 host_rvalid); // R2
  AST_SPARE_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(spare_bank) <= NUM_BANKS); // R4
  AST_SPARE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !refresh_done |-> $stable(spare_bank)); // R4
  AST_SPARE_STEP: assert property (@(posedge clk) disable iff (rst)
    refresh_done |-> (spare_bank == (($past(spare_bank) == '0) ? PB_W'(NUM_BANKS)
                                     : $past(spare_bank) - PB_W'(1)))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    refresh_done |=> !refresh_done); // R5
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(refresh_busy) |-> refresh_done); // R5
  AST_REQ_STARTS: assert property (@(posedge clk) disable iff (rst)
    (!refresh_busy && refresh_req) |=> refresh_busy); // R7
  AST_DEADLINE: assert property (@(posedge clk) disable iff (rst)
    idle_cnt_q <= REFRESH_INTERVAL); // R8

endmodule

bind rsb_refresh_ctrl rsb_checker #(
  .NUM_BANKS        (NUM_BANKS),
  .REFRESH_INTERVAL (REFRESH_INTERVAL)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .host_en      (host_en),
  .host_we      (host_we),
  .host_lbank   (host_lbank),
  .host_rvalid  (host_rvalid),
  .refresh_req  (refresh_req),
  .refresh_busy (refresh_busy),
  .refresh_done (refresh_done),
  .spare_bank   (spare_bank)
);

// File: tb/rsb_refresh_ctrl_tb.sv
module rsb_refresh_ctrl_tb_top;

  localparam int N    = 4;
  localparam int W    = 8;
  localparam int DW   = 16;
  localparam int IVL  = 64;
  localparam int LB_W = $clog2(N);
  localparam int PB_W = $clog2(N + 1);
  localparam int WA_W = $clog2(W);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            host_en = 1'b0, host_we = 1'b0;
  logic [LB_W-1:0] host_lbank = '0;
  logic [WA_W-1:0] host_word = '0;
  logic [DW-1:0]   host_wdata = '0;
  logic [DW-1:0]   host_rdata;
  logic            host_rvalid;
  logic            refresh_req = 1'b0;
  logic            refresh_busy, refresh_done;
  logic [PB_W-1:0] spare_bank;

  always #2 clk = ~clk;   // 250 MHz

  rsb_refresh_ctrl #(
    .NUM_BANKS(N), .BANK_WORDS(W), .DATA_W(DW), .REFRESH_INTERVAL(IVL)
  ) dut_i (
    .clk(clk), .rst(rst), .host_en(host_en), .host_we(host_we),
    .host_lbank(host_lbank), .host_word(host_word), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .refresh_req(refresh_req),
    .refresh_busy(refresh_busy), .refresh_done(refresh_done), .spare_bank(spare_bank)
  );

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] mem_m [N][W];
  int model_map [N];
  int model_spare;
  int done_cnt = 0;
  int busy_len = 0, last_len = 0;
  bit prev_busy = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Model of the ring: updated on each completion pulse, spare checked (R4).
  always @(negedge clk) begin
    if (rst) begin
      for (int l = 0; l < N; l++) model_map[l] = l;
      model_spare = N;
      busy_len = 0;
      prev_busy = 1'b0;
    end else begin
      if (refresh_done) begin
        int src;
        src = (model_spare == 0) ? N : model_spare - 1;
        for (int l = 0; l < N; l++) if (model_map[l] == src) model_map[l] = model_spare;
        model_spare = src;
        done_cnt++;
        chk(int'(spare_bank) == model_spare, "R4", "spare after step", spare_bank, model_spare);
      end
      if (refresh_busy) busy_len++;
      else if (prev_busy) begin
        last_len = busy_len;
        busy_len = 0;
      end
      prev_busy = refresh_busy;
    end
  end

  function automatic logic [DW-1:0] pat(input int l, input int w, input int seed);
    return DW'((seed << 8) | (l << 4) | w);
  endfunction

  task automatic host_write(input int l, input int w, input logic [DW-1:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b1;
    host_lbank = LB_W'(l); host_word = WA_W'(w); host_wdata = d;
    mem_m[l][w] = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read_chk(input int l, input int w, input string req);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0;
    host_lbank = LB_W'(l); host_word = WA_W'(w);
    @(negedge clk);
    host_en = 1'b0;
    @(negedge clk);
    chk(host_rvalid == 1'b1, "R2", "rvalid two cycles after read", host_rvalid, 1);
    chk(host_rdata == mem_m[l][w], req, $sformatf("data l%0d w%0d", l, w), host_rdata, mem_m[l][w]);
  endtask

  task automatic read_all(input string req);
    for (int l = 0; l < N; l++)
      for (int w = 0; w < W; w++) host_read_chk(l, w, req);
  endtask

  task automatic wait_idle();
    while (refresh_busy) @(negedge clk);
  endtask

  task automatic pulse_req();
    @(negedge clk);
    refresh_req = 1'b1;
    @(negedge clk);
    refresh_req = 1'b0;
  endtask

  task automatic t_reset();
    chk(int'(spare_bank) == N, "R1", "reset spare", spare_bank, N);
    chk(refresh_busy == 1'b0, "R1", "reset busy", refresh_busy, 0);
    chk(refresh_done == 1'b0, "R1", "reset done", refresh_done, 0);
    chk(host_rvalid == 1'b0, "R1", "reset rvalid", host_rvalid, 0);
  endtask

  task automatic t_fill(input int seed);
    for (int l = 0; l < N; l++)
      for (int w = 0; w < W; w++) host_write(l, w, pat(l, w, seed));
    read_all("R3");
  endtask

  // R6, R5, R7 on an undisturbed step, then R8 on the idle gap that follows.
  task automatic t_step_and_deadline();
    int idle;
    wait_idle();
    pulse_req();
    chk(refresh_busy == 1'b1, "R7", "busy after request", refresh_busy, 1);
    while (refresh_busy) @(negedge clk);
    chk(refresh_done == 1'b1, "R5", "done when busy falls", refresh_done, 1);
    chk(last_len == W + 2, "R6", "undisturbed step length", last_len, W + 2);
    idle = 1;
    for (int k = 0; k < 4 * IVL; k++) begin
      @(negedge clk);
      if (k == 0) chk(refresh_done == 1'b0, "R5", "done is one cycle", refresh_done, 0);
      if (refresh_busy) break;
      idle++;
    end
    chk(idle == IVL, "R8", "idle cycles before automatic step", idle, IVL);
    wait_idle();
  endtask

  task automatic t_req_while_busy();
    int d0;
    wait_idle();
    pulse_req();
    repeat (3) @(negedge clk);
    d0 = done_cnt;
    refresh_req = 1'b1;   // dropped: step already running
    @(negedge clk);
    refresh_req = 1'b0;
    wait_idle();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(refresh_busy == 1'b0, "R7", "no queued step", refresh_busy, 0);
    end
    chk(done_cnt == d0 + 1, "R7", "single completion", done_cnt, d0 + 1);
  endtask

  // R9, R10, R11: heavy host traffic on the bank under copy.
  task automatic t_copy_traffic();
    int src, sl;
    wait_idle();
    src = (model_spare == 0) ? N : model_spare - 1;
    sl = 0;
    for (int l = 0; l < N; l++) if (model_map[l] == src) sl = l;
    pulse_req();
    host_write(sl, 1, 16'hA001);
    chk(refresh_busy == 1'b1, "R10", "copy still running at read", refresh_busy, 1);
    host_read_chk(sl, W - 1, "R10");
    host_write(sl, W - 1, 16'hA0F7);
    host_write(sl, 2, 16'hA002);
    host_write(sl, 3, 16'hA003);
    host_read_chk(sl, 0, "R10");
    host_write(sl, 0, 16'hA000);
    wait_idle();
    @(negedge clk);
    chk(last_len > W + 2, "R11", "stalled step length", last_len, W + 3);
    for (int w = 0; w < W; w++) host_read_chk(sl, w, "R9");
    read_all("R3");
  endtask

  // R3, R4: two laps back to back with writes spread over all banks.
  task automatic t_laps();
    int target;
    wait_idle();
    target = done_cnt + 2 * (N + 1);
    refresh_req = 1'b1;
    for (int k = 0; k < 3 * N * W; k++) begin
      int l, w;
      l = (k * 3) % N;
      w = (k * 5) % W;
      host_write(l, w, pat(l, w, 7 + k));
    end
    while (done_cnt < target) @(negedge clk);
    refresh_req = 1'b0;
    wait_idle();
    @(negedge clk);
    chk(int'(spare_bank) == model_spare, "R4", "spare after laps", spare_bank, model_spare);
    read_all("R3");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill(1);
    t_step_and_deadline();
    t_req_while_busy();
    t_copy_traffic();
    t_laps();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule